// File: doc/BRIEF.md
# Sequence Configuration Cache

This block holds the array configurations produced when a run of instructions is translated for the reconfigurable accelerator. Each entry is found by the program counter of the first instruction of its run. When the fetch stage presents a PC, the block answers in the same cycle with hit or miss. On a hit it also gives the stored configuration word and the PC at which normal execution resumes after the accelerated run. A hit means the sequence needs no new analysis.

When the translator finishes a run, it commits the start PC, the instruction count, the configuration word and the resume PC through a write port. Runs of three or fewer instructions are dropped. A commit whose start PC is already cached rewrites that entry where it stands. Any other accepted commit fills the slot named by a first-in first-out pointer. Once every slot is full, that pointer points at the oldest insertion, so the oldest insertion is the one replaced. The configuration is an opaque word of fixed width.

Top module: `seqcfg_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every entry and returns the replacement pointer to slot 0, so every lookup misses after it.
- R2: Lookup is combinational: in the same cycle that `lk_pc` equals the tag of a valid entry, `lk_hit` is 1 and `lk_cfg`/`lk_resume` carry that entry's configuration and resume PC.
- R3: When no valid entry matches `lk_pc`, `lk_hit` is 0 and `lk_cfg` and `lk_resume` are all zeros.
- R4: A commit (`cm_valid` high) with `cm_len` of 4 or more becomes visible to lookups from the clock edge at which it is presented.
- R5: A commit with `cm_len` of 3 or less changes no entry and does not move the replacement pointer.
- R6: Commits of new start PCs fill slots in arrival order. When all DEPTH slots are valid, the next new commit replaces the entry inserted earliest.
- R7: A long commit whose `cm_pc` matches a valid entry overwrites that entry's configuration and resume PC in place. It does not move the replacement pointer, and it does not refresh the entry's age.
- R8: The full PC width is the tag: PCs that differ in any bit, including the most significant, never alias.
- R9: While `cm_valid` is low, the commit inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | A valid entry matches `lk_pc` |
| lk_cfg | output | CFG_W | Configuration word of the matching entry, zero on miss |
| lk_resume | output | PC_W | PC following the accelerated run, zero on miss |
| cm_valid | input | 1 | Commit strobe for one cycle |
| cm_pc | input | PC_W | Start PC of the translated run |
| cm_len | input | LEN_W | Number of instructions in the run |
| cm_cfg | input | CFG_W | Configuration word from the translation buffer |
| cm_resume | input | PC_W | PC after the last merged instruction |

## Verification
The hardest case to reach is an entry that has been rewritten in place and then has to be evicted on time. The stimulus first fills all eight slots. It then rewrites the oldest entry through a matching commit, and then commits a new PC. The lookups that follow must show that the rewritten entry is the one evicted, because an in-place update does not make an entry younger. A second new commit must then evict the next-oldest entry. Short commits and commits with the strobe low are mixed into the vector table, so that an ignored commit is seen as an unchanged lookup result.

// File: rtl/seqcfg_pkg.sv
package seqcfg_pkg;

    // Decision taken for the commit presented in the current cycle
    typedef enum logic [1:0] {
        CM_NONE    = 2'd0,
        CM_INSERT  = 2'd1,
        CM_REPLACE = 2'd2
    } cm_op_e;

    function automatic cm_op_e decide_op(input logic strobe,
                                         input logic long_enough,
                                         input logic already_cached);
        if (!strobe || !long_enough) return CM_NONE;
        if (already_cached)          return CM_REPLACE;
        return CM_INSERT;
    endfunction

endpackage

// File: rtl/seqcfg_match.sv
module seqcfg_match #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [PC_W-1:0]              key,
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][PC_W-1:0]   tags,
    output logic [DEPTH-1:0]             match_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/seqcfg_victim.sv
module seqcfg_victim #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            if (ptr_q == IDX_W'(DEPTH - 1)) ptr_d = '0;
            else                            ptr_d = ptr_q + 1'b1;
        end
        if (rst) ptr_d = '0;
    end

    always_ff @(posedge clk) begin
        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/seqcfg_store.sv
module seqcfg_store #(
    parameter int PC_W  = 32,
    parameter int CFG_W = 64,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic [PC_W-1:0]               wtag,
    input  logic [CFG_W-1:0]              wcfg,
    input  logic [PC_W-1:0]               wres,
    output logic [DEPTH-1:0]              vld,
    output logic [DEPTH-1:0][PC_W-1:0]    tags,
    output logic [DEPTH-1:0][CFG_W-1:0]   cfgs,
    output logic [DEPTH-1:0][PC_W-1:0]    ress
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][PC_W-1:0]   tag;
        logic [DEPTH-1:0][CFG_W-1:0]  cfg;
        logic [DEPTH-1:0][PC_W-1:0]   res;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.vld[widx] = 1'b1;
            st_d.tag[widx] = wtag;
            st_d.cfg[widx] = wcfg;
            st_d.res[widx] = wres;
        end
        if (rst) st_d.vld = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign vld  = st_q.vld;
    assign tags = st_q.tag;
    assign cfgs = st_q.cfg;
    assign ress = st_q.res;

    // R4
    written_slot_valid_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> vld[$past(widx)]);

endmodule

// File: rtl/seqcfg_cache.sv
module seqcfg_cache
    import seqcfg_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int CFG_W   = 64,
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 6,
    parameter int MIN_LEN = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [CFG_W-1:0] lk_cfg,
    output logic [PC_W-1:0]  lk_resume,
    input  logic             cm_valid,
    input  logic [PC_W-1:0]  cm_pc,
    input  logic [LEN_W-1:0] cm_len,
    input  logic [CFG_W-1:0] cm_cfg,
    input  logic [PC_W-1:0]  cm_resume
);

    logic [DEPTH-1:0]             vld;
    logic [DEPTH-1:0][PC_W-1:0]   tags;
    logic [DEPTH-1:0][CFG_W-1:0]  cfgs;
    logic [DEPTH-1:0][PC_W-1:0]   ress;

    logic [DEPTH-1:0] lk_vec, cm_vec;
    logic             lk_match, cm_match;
    logic [IDX_W-1:0] lk_idx, cm_idx, fifo_ptr, wr_idx;
    logic             long_run;
    cm_op_e           op;

    seqcfg_match #(.PC_W(PC_W), .DEPTH(DEPTH)) u_lk_match (
        .key(lk_pc), .vld(vld), .tags(tags),
        .match_vec(lk_vec), .hit(lk_match), .idx(lk_idx)
    );

    seqcfg_match #(.PC_W(PC_W), .DEPTH(DEPTH)) u_cm_match (
        .key(cm_pc), .vld(vld), .tags(tags),
        .match_vec(cm_vec), .hit(cm_match), .idx(cm_idx)
    );

    always_comb begin
        long_run = (cm_len >= LEN_W'(MIN_LEN));
        op       = decide_op(cm_valid, long_run, cm_match);
        wr_idx   = (op == CM_REPLACE) ? cm_idx : fifo_ptr;
    end

    seqcfg_victim #(.DEPTH(DEPTH)) u_victim (
        .clk(clk), .rst(rst), .advance(op == CM_INSERT), .ptr(fifo_ptr)
    );

    seqcfg_store #(.PC_W(PC_W), .CFG_W(CFG_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .we(op != CM_NONE), .widx(wr_idx),
        .wtag(cm_pc), .wcfg(cm_cfg), .wres(cm_resume),
        .vld(vld), .tags(tags), .cfgs(cfgs), .ress(ress)
    );

    always_comb begin
        lk_hit    = lk_match;
        lk_cfg    = '0;
        lk_resume = '0;
        if (lk_match) begin
            lk_cfg    = cfgs[lk_idx];
            lk_resume = ress[lk_idx];
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (vld == '0) && (fifo_ptr == '0));

    // R8
    lookup_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));

    // R7
    commit_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cm_vec));

    // R5
    short_commit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && !long_run) |=> $stable(vld) && $stable(fifo_ptr));

    // R7
    replace_holds_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && long_run && cm_match) |=> $stable(fifo_ptr));

    // R6
    insert_moves_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && long_run && !cm_match) |=>
            fifo_ptr == (($past(fifo_ptr) == IDX_W'(DEPTH - 1)) ? '0 : $past(fifo_ptr) + 1'b1));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_cfg == '0) && (lk_resume == '0));

endmodule

// File: tb/seqcfg_cache_tb.sv
module seqcfg_cache_tb;

    localparam int PC_W = 32, CFG_W = 64, LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_hit;
    logic [CFG_W-1:0] lk_cfg;
    logic [PC_W-1:0]  lk_resume;
    logic             cm_valid = 1'b0;
    logic [PC_W-1:0]  cm_pc = '0;
    logic [LEN_W-1:0] cm_len = '0;
    logic [CFG_W-1:0] cm_cfg = '0;
    logic [PC_W-1:0]  cm_resume = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seqcfg_cache u_dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_cfg(lk_cfg), .lk_resume(lk_resume), .cm_valid(cm_valid),
        .cm_pc(cm_pc), .cm_len(cm_len), .cm_cfg(cm_cfg), .cm_resume(cm_resume)
    );

    typedef struct packed {
        logic [15:0]      tag;
        logic             cv;
        logic [PC_W-1:0]  cpc;
        logic [LEN_W-1:0] clen;
        logic [CFG_W-1:0] ccfg;
        logic [PC_W-1:0]  cres;
        logic [PC_W-1:0]  lpc;
        logic             ehit;
        logic [CFG_W-1:0] ecfg;
        logic [PC_W-1:0]  eres;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{16'h5231, 1'b0, 32'h0, 6'd0, 64'h0, 32'h0, 32'h100, 1'b0, 64'h0, 32'h0},
        '{16'h5234, 1'b1, 32'h100, 6'd4, 64'hAAAA_0001, 32'h110, 32'h100, 1'b1, 64'hAAAA_0001, 32'h110},
        '{16'h5235, 1'b1, 32'h200, 6'd3, 64'hBAD0, 32'h20C, 32'h200, 1'b0, 64'h0, 32'h0},
        '{16'h5239, 1'b0, 32'h300, 6'd8, 64'hBAD1, 32'h320, 32'h300, 1'b0, 64'h0, 32'h0},
        '{16'h5232, 1'b1, 32'h300, 6'd8, 64'hBBBB_0002, 32'h320, 32'h100, 1'b1, 64'hAAAA_0001, 32'h110},
        '{16'h5238, 1'b0, 32'h0, 6'd0, 64'h0, 32'h0, 32'h8000_0100, 1'b0, 64'h0, 32'h0},
        '{16'h5237, 1'b1, 32'h100, 6'd5, 64'hCCCC_0003, 32'h114, 32'h100, 1'b1, 64'hCCCC_0003, 32'h114},
        '{16'h5236, 1'b0, 32'h0, 6'd0, 64'h0, 32'h0, 32'h300, 1'b1, 64'hBBBB_0002, 32'h320}
    };

    task automatic check(input string req, input logic [PC_W-1:0] pc,
                         input logic ehit, input logic [CFG_W-1:0] ecfg,
                         input logic [PC_W-1:0] eres);
        lk_pc = pc;
        #2;
        checks++;
        if (lk_hit !== ehit || lk_cfg !== ecfg || lk_resume !== eres) begin
            errors++;
            $display("FAIL %s pc=%h actual hit=%b cfg=%h res=%h expected hit=%b cfg=%h res=%h",
                     req, pc, lk_hit, lk_cfg, lk_resume, ehit, ecfg, eres);
        end
    endtask

    task automatic commit(input logic v, input logic [PC_W-1:0] pc,
                          input logic [LEN_W-1:0] len, input logic [CFG_W-1:0] cfg,
                          input logic [PC_W-1:0] res);
        @(negedge clk);
        cm_valid = v; cm_pc = pc; cm_len = len; cm_cfg = cfg; cm_resume = res;
        @(posedge clk);
        #1;
        cm_valid = 1'b0;
    endtask

    function automatic string tag_name(input logic [15:0] t);
        case (t)
            16'h5231: return "R1";
            16'h5232: return "R2";
            16'h5234: return "R4";
            16'h5235: return "R5";
            16'h5236: return "R6";
            16'h5237: return "R7";
            16'h5238: return "R8";
            default:  return "R9";
        endcase
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset state", 32'h0, 1'b0, '0, '0);

        // vector table: commit then lookup; R3 covered by every miss row
        for (int i = 0; i < NV; i++) begin
            commit(VT[i].cv, VT[i].cpc, VT[i].clen, VT[i].ccfg, VT[i].cres);
            check(tag_name(VT[i].tag), VT[i].lpc, VT[i].ehit, VT[i].ecfg, VT[i].eres);
        end

        // R6: fill slots 2..7 (0x100 in slot 0, 0x300 in slot 1)
        for (int k = 0; k < 6; k++) begin
            commit(1'b1, 32'h400 + 32'(k) * 32'h100, 6'd6, 64'hF000 + 64'(k), 32'h1400 + 32'(k));
        end
        for (int k = 0; k < 6; k++) begin
            check("R6 full", 32'h400 + 32'(k) * 32'h100, 1'b1, 64'hF000 + 64'(k), 32'h1400 + 32'(k));
        end
        check("R6 full oldest", 32'h100, 1'b1, 64'hCCCC_0003, 32'h114);

        // R7: rewrite oldest entry in place; must not refresh its age
        commit(1'b1, 32'h100, 6'd9, 64'hDDDD_0004, 32'h124);
        check("R7 rewrite", 32'h100, 1'b1, 64'hDDDD_0004, 32'h124);
        check("R7 neighbour kept", 32'h900, 1'b1, 64'hF005, 32'h1405);

        // R6: new PC evicts slot 0 (0x100), then slot 1 (0x300)
        commit(1'b1, 32'hA00, 6'd4, 64'hEEEE_0005, 32'hA10);
        check("R6 evict oldest", 32'h100, 1'b0, '0, '0);
        check("R6 new entry", 32'hA00, 1'b1, 64'hEEEE_0005, 32'hA10);
        check("R6 second oldest kept", 32'h300, 1'b1, 64'hBBBB_0002, 32'h320);
        commit(1'b1, 32'hB00, 6'd63, 64'h1234, 32'hB40);
        check("R6 evict next", 32'h300, 1'b0, '0, '0);
        check("R6 other kept", 32'h400, 1'b1, 64'hF000, 32'h1400);

        // R5: short commit when full evicts nothing
        commit(1'b1, 32'hC00, 6'd3, 64'h9, 32'hC0C);
        check("R5 short not stored", 32'hC00, 1'b0, '0, '0);
        check("R5 no eviction", 32'h400, 1'b1, 64'hF000, 32'h1400);

        // R1: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R1 after reset", 32'hA00, 1'b0, '0, '0);
        check("R1 after reset", 32'h500, 1'b0, '0, '0);
        commit(1'b1, 32'hD00, 6'd4, 64'h77, 32'hD10);
        check("R1 refill", 32'hD00, 1'b1, 64'h77, 32'hD10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule